// File: doc/BRIEF.md
# Configurable Serial Audio Transmitter

This block turns stereo pairs of 16-bit two's-complement PCM samples into a three-wire serial audio stream. The three wires are a bit clock, a word select that marks the left or right channel, and serial data. The bit clock runs from a half-period tick derived from the master clock. Each tick toggles the bit clock. New serial data and word-select values are launched on the falling bit-clock edge, so a DAC samples them on the rising edge.

A producer offers one left/right pair at a time through a valid/ready handshake. The block holds at most one pending pair. It moves that pair into the frame registers only when a new frame starts, that is, at the first bit of a left slot. If no pair is pending at that moment, the frame carries zeros.

A four-bit mode word selects the framing:
- slot length of 16 or 32 bits per channel;
- which word-select level means left;
- whether the word select leads the data by one bit (I2S style);
- left or right placement of the 16 data bits within a 32-bit slot.

The mode is sampled only at frame starts, so a frame is never built from two different framings.

Top module: `audio_serial_tx`

## Requirements
- R1: While reset is held, sclk_o, ws_o and sd_o are 0 and in_ready is 1.
- R2: With mode = 0 (32-bit slots), a frame is 64 bits: a left slot of 16 data bits MSB first followed by 16 zero bits, then a right slot laid out the same way.
- R3: Mode bit 0 = 1 selects 16-bit slots, so a frame is 32 bits, left then right, each MSB first. Mode bit 3 has no effect in this slot length.
- R4: Mode bit 3 = 1 with 32-bit slots right-aligns the data: 16 zero bits, then the 16 data bits MSB first.
- R5: Mode bit 1 gives the word-select level that marks the left slot. With 0, left is low; with 1, left is high.
- R6: Mode bit 2 = 1 moves every word-select transition one bit earlier, so it leads the first bit of a slot by one bit period. With 0, the transition coincides with the first bit of the slot.
- R7: sd_o and ws_o change only in the clock cycle in which sclk_o falls, so they are stable at each rising edge.
- R8: sclk_o toggles in the clock cycle after every half_tick pulse and holds otherwise.
- R9: A pair is accepted when in_valid and in_ready are both high. in_ready then stays low until the falling edge that starts the next frame. A pair offered while in_ready is low is ignored.
- R10: If no pair is pending when a frame starts, the whole frame carries zero data bits while the word select keeps its pattern.
- R11: A mode change is applied only from the next frame start. The current frame completes in its old framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_tick | input | 1 | Clock-enable pulse, one per half bit-clock period |
| mode_i | input | 4 | Framing mode: bit0 short slot, bit1 left-high, bit2 one-bit delay, bit3 right-align |
| in_valid | input | 1 | A sample pair is offered |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| in_ready | output | 1 | The pending-pair slot is free |
| sclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | 1 | Serial data |

## Verification
Each result is due at a known point:
- sclk_o changes one clock after a half_tick pulse.
- sd_o and ws_o for a bit position are registered in the same cycle as the falling bit-clock edge, and are read at the next rising edge.
- in_ready falls one clock after an accepted pair and rises in the cycle of the frame-opening falling edge.

Since reset leaves the bit clock low, the first rising edge after reset carries the reset values. Bit position zero of the first frame therefore appears at the second rising edge.

The bench samples on the opposite clock edge and logs sd_o and ws_o at every observed rise of sclk_o. It compares the log against frames it builds from the requirements, indexed by bit-clock rise rather than by clock cycle.

// File: rtl/atx_pkg.sv
package atx_pkg;
   // Mode word; the bit positions are part of the external contract.
   typedef struct packed {
      logic right_just;   // bit 3
      logic lead_ws;      // bit 2
      logic left_high;    // bit 1
      logic short_slot;   // bit 0
   } atx_mode_t;
endpackage

// File: rtl/atx_bitclk.sv
module atx_bitclk (
   input  logic clk,
   input  logic rst_n,
   input  logic half_tick,
   output logic sclk,
   output logic fall_now
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sclk <= 1'b0;
      else if (half_tick) sclk <= ~sclk;
   end

   // falling edge of the bit clock happens on this clock edge
   assign fall_now = half_tick & sclk;
endmodule

// File: rtl/atx_pend_buf.sv
module atx_pend_buf #(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_l,
   input  logic [SAMPLE_W-1:0] in_r,
   input  logic                take,
   output logic                in_ready,
   output logic                full,
   output logic [SAMPLE_W-1:0] out_l,
   output logic [SAMPLE_W-1:0] out_r
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full  <= 1'b0;
         out_l <= '0;
         out_r <= '0;
      end else if (in_valid && !full) begin
         full  <= 1'b1;
         out_l <= in_l;
         out_r <= in_r;
      end else if (take) begin
         full  <= 1'b0;
      end
   end

   assign in_ready = ~full;
endmodule

// File: rtl/atx_slot_map.sv
module atx_slot_map
   import atx_pkg::*;
#(
   parameter int SAMPLE_W  = 16,
   parameter int LONG_SLOT = 32,
   parameter bit JUST_EN   = 1'b1,
   parameter int PW        = 6
) (
   input  logic [PW-1:0]       pos,
   input  atx_mode_t           mode,
   input  logic [SAMPLE_W-1:0] smp_l,
   input  logic [SAMPLE_W-1:0] smp_r,
   output logic                bit_o,
   output logic                ws_o
);
   localparam int IW  = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;
   localparam int PAD = LONG_SLOT - SAMPLE_W;

   logic use_rj;

   generate
      if (JUST_EN) begin : g_rj
         assign use_rj = mode.right_just & ~mode.short_slot;
      end else begin : g_no_rj
         assign use_rj = 1'b0;
      end
   endgenerate

   int                  p_i, slen_i, q_i, np_i, idx_i;
   logic                in_right, nxt_right;
   logic [SAMPLE_W-1:0] smp;

   always_comb begin
      p_i       = int'(pos);
      slen_i    = mode.short_slot ? SAMPLE_W : LONG_SLOT;
      in_right  = (p_i >= slen_i);
      q_i       = in_right ? (p_i - slen_i) : p_i;
      np_i      = (p_i >= 2*slen_i - 1) ? 0 : (p_i + 1);
      nxt_right = (np_i >= slen_i);
      smp       = in_right ? smp_r : smp_l;
      idx_i     = 0;
      bit_o     = 1'b0;
      if (use_rj) begin
         if (q_i >= PAD) begin
            idx_i = LONG_SLOT - 1 - q_i;
            bit_o = smp[IW'(idx_i)];
         end
      end else if (q_i < SAMPLE_W) begin
         idx_i = SAMPLE_W - 1 - q_i;
         bit_o = smp[IW'(idx_i)];
      end
      ws_o = (mode.lead_ws ? nxt_right : in_right) ^ mode.left_high;
   end
endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
   import atx_pkg::*;
#(
   parameter int SAMPLE_W  = 16,
   parameter int LONG_SLOT = 32,
   parameter bit JUST_EN   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                half_tick,
   input  logic [3:0]          mode_i,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   output logic                in_ready,
   output logic                sclk_o,
   output logic                ws_o,
   output logic                sd_o
);
   localparam int PW = $clog2(2*LONG_SLOT);

   generate
      if (SAMPLE_W < 2) begin : g_bad_w
         $error("SAMPLE_W must be at least 2");
      end
      if (LONG_SLOT < SAMPLE_W) begin : g_bad_slot
         $error("LONG_SLOT must not be shorter than SAMPLE_W");
      end
   endgenerate

   logic                fall_now, wrap, take;
   logic                pend_full, map_bit, map_ws;
   logic [SAMPLE_W-1:0] pend_l, pend_r, cur_l, cur_r, nxt_l, nxt_r;
   logic [PW-1:0]       pos, nxt_pos, last_pos;
   atx_mode_t           mode_q, nxt_mode;

   atx_bitclk i_bitclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_tick (half_tick),
      .sclk      (sclk_o),
      .fall_now  (fall_now)
   );

   atx_pend_buf #(.SAMPLE_W(SAMPLE_W)) i_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_l     (in_left),
      .in_r     (in_right),
      .take     (take),
      .in_ready (in_ready),
      .full     (pend_full),
      .out_l    (pend_l),
      .out_r    (pend_r)
   );

   assign last_pos = mode_q.short_slot ? PW'(2*SAMPLE_W - 1) : PW'(2*LONG_SLOT - 1);
   assign wrap     = fall_now && (pos == last_pos);
   assign take     = wrap && pend_full;
   assign nxt_pos  = wrap ? '0 : (pos + PW'(1));
   assign nxt_mode = wrap ? atx_mode_t'(mode_i) : mode_q;
   assign nxt_l    = wrap ? (pend_full ? pend_l : '0) : cur_l;
   assign nxt_r    = wrap ? (pend_full ? pend_r : '0) : cur_r;

   atx_slot_map #(
      .SAMPLE_W  (SAMPLE_W),
      .LONG_SLOT (LONG_SLOT),
      .JUST_EN   (JUST_EN),
      .PW        (PW)
   ) i_map (
      .pos   (nxt_pos),
      .mode  (nxt_mode),
      .smp_l (nxt_l),
      .smp_r (nxt_r),
      .bit_o (map_bit),
      .ws_o  (map_ws)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos    <= PW'(2*LONG_SLOT - 1);
         mode_q <= '0;
         cur_l  <= '0;
         cur_r  <= '0;
         sd_o   <= 1'b0;
         ws_o   <= 1'b0;
      end else if (fall_now) begin
         pos    <= nxt_pos;
         mode_q <= nxt_mode;
         cur_l  <= nxt_l;
         cur_r  <= nxt_r;
         sd_o   <= map_bit;
         ws_o   <= map_ws;
      end
   end
endmodule

// File: rtl/atx_checker.sv
module atx_checker (
   input logic clk,
   input logic rst_n,
   input logic half_tick,
   input logic in_valid,
   input logic in_ready,
   input logic sclk_o,
   input logic ws_o,
   input logic sd_o
);
   // R8
   sclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      half_tick |=> (sclk_o != $past(sclk_o)));
   // R8
   sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !half_tick |=> $stable(sclk_o));
   // R7
   sd_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(sclk_o) |-> $stable(sd_o));
   // R7
   ws_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(sclk_o) |-> $stable(ws_o));
   // R9
   accept_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);
   // R9
   ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> $fell(sclk_o));
endmodule

bind audio_serial_tx atx_checker i_atx_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .half_tick (half_tick),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .sclk_o    (sclk_o),
   .ws_o      (ws_o),
   .sd_o      (sd_o)
);

// File: tb/test_audio_serial_tx.sv
`timescale 1ns/1ps
module test_audio_serial_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        half_tick = 1'b0;
   logic [3:0]  mode_i = 4'h0;
   logic        in_valid = 1'b0;
   logic [15:0] in_left = 16'h0;
   logic [15:0] in_right = 16'h0;
   logic        in_ready, sclk_o, ws_o, sd_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   audio_serial_tx i_audio_serial_tx (
      .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .mode_i(mode_i),
      .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
      .in_ready(in_ready), .sclk_o(sclk_o), .ws_o(ws_o), .sd_o(sd_o)
   );

   // half-period tick every 4 clocks, driven away from the active edge
   int tick_cnt = 0;
   always @(negedge clk) begin
      tick_cnt  <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
      half_tick <= (tick_cnt == 3);
   end

   // log data and word select at each rise of the bit clock
   logic log_sd [0:511];
   logic log_ws [0:511];
   int   nbits = 0;
   logic prev_sclk = 1'b0;
   always @(negedge clk) begin
      if (rst_n && sclk_o && !prev_sclk && nbits < 512) begin
         log_sd[nbits] = sd_o;
         log_ws[nbits] = ws_o;
         nbits = nbits + 1;
      end
      prev_sclk = rst_n ? sclk_o : 1'b0;
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic logic exp_sd(input logic [3:0] m, input logic [15:0] l,
                                   input logic [15:0] r, input int p);
      int slen = m[0] ? 16 : 32;
      int q = p % slen;
      logic [15:0] s = (p >= slen) ? r : l;
      if (!m[0] && m[3]) return (q >= 16) ? s[31-q] : 1'b0;
      return (q < 16) ? s[15-q] : 1'b0;
   endfunction

   function automatic logic exp_ws(input logic [3:0] m, input int p);
      int slen = m[0] ? 16 : 32;
      int pp = m[2] ? ((p + 1) % (2*slen)) : p;
      return logic'(pp >= slen) ^ m[1];
   endfunction

   function automatic string tag_of(input logic [3:0] m);
      if (m[0])      return "R3";
      if (m[3])      return "R4";
      if (m[2])      return "R6";
      if (m[1])      return "R5";
      return "R2";
   endfunction

   // frame bit p is log entry base+p
   task automatic check_frame(input int base, input logic [3:0] m,
                              input logic [15:0] l, input logic [15:0] r,
                              input string tag);
      int flen = m[0] ? 32 : 64;
      int sd_err = -1;
      int ws_err = -1;
      for (int p = 0; p < flen; p++) begin
         if (sd_err < 0 && log_sd[base+p] !== exp_sd(m, l, r, p)) sd_err = p;
         if (ws_err < 0 && log_ws[base+p] !== exp_ws(m, p)) ws_err = p;
      end
      chk(sd_err < 0, tag, $sformatf("data mode=%h first bad bit", m), sd_err, -1);
      chk(ws_err < 0, tag, $sformatf("word select mode=%h first bad bit", m), ws_err, -1);
   endtask

   task automatic start(input logic [3:0] m, input bit v,
                        input logic [15:0] l, input logic [15:0] r);
      rst_n = 1'b0;
      mode_i = m; in_valid = v; in_left = l; in_right = r;
      repeat (3) @(negedge clk);
      nbits = 0;
      rst_n = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_bits(input int n);
      while (nbits < n) @(negedge clk);
   endtask

   // {mode, left, right}
   localparam logic [35:0] VEC [10] = '{
      {4'b0000, 16'hA5C3, 16'h1E0F},
      {4'b0001, 16'h8001, 16'h7FFE},
      {4'b0010, 16'h1234, 16'hFEDC},
      {4'b0100, 16'hC001, 16'h0003},
      {4'b1000, 16'h9AB7, 16'h4C21},
      {4'b1001, 16'hF00F, 16'h0FF0},
      {4'b0110, 16'h5555, 16'hAAAA},
      {4'b1110, 16'h8000, 16'h0001},
      {4'b0101, 16'h7F00, 16'h00FF},
      {4'b1111, 16'h3C5A, 16'hE187}
   };

   initial begin
      // R1: reset values
      repeat (4) @(negedge clk);
      chk(sclk_o == 1'b0, "R1", "sclk in reset", sclk_o, 0);
      chk(ws_o == 1'b0, "R1", "ws in reset", ws_o, 0);
      chk(sd_o == 1'b0, "R1", "sd in reset", sd_o, 0);
      chk(in_ready == 1'b1, "R1", "ready in reset", in_ready, 1);

      // table of framings, each from a fresh reset; log entry 0 is pre-frame
      for (int i = 0; i < 10; i++) begin
         logic [3:0]  m = VEC[i][35:32];
         logic [15:0] l = VEC[i][31:16];
         logic [15:0] r = VEC[i][15:0];
         start(m, 1'b1, l, r);
         wait_bits(1 + (m[0] ? 32 : 64));
         check_frame(1, m, l, r, tag_of(m));
      end

      // R10: nothing pending -> zero data, word select unchanged
      start(4'b0010, 1'b0, 16'hFFFF, 16'hFFFF);
      wait_bits(1 + 64);
      check_frame(1, 4'b0010, 16'h0, 16'h0, "R10");

      // R9, R11, R10: backpressure, ignored offer, mode change mid-frame
      start(4'b0000, 1'b1, 16'hBEEF, 16'h0F1E);
      wait_bits(3);
      in_valid = 1'b1; in_left = 16'h6C39; in_right = 16'h9A0B;
      @(negedge clk);
      in_valid = 1'b0;
      chk(in_ready == 1'b0, "R9", "ready after accept", in_ready, 0);
      mode_i = 4'b0011;
      in_valid = 1'b1; in_left = 16'hFFFF; in_right = 16'hFFFF;
      repeat (5) @(negedge clk);
      in_valid = 1'b0;
      wait_bits(40);
      chk(in_ready == 1'b0, "R9", "ready mid-frame while pending", in_ready, 0);
      wait_bits(1 + 64 + 2);
      chk(in_ready == 1'b1, "R9", "ready after frame start", in_ready, 1);
      wait_bits(1 + 64 + 32 + 32);
      check_frame(1, 4'b0000, 16'hBEEF, 16'h0F1E, "R11");
      check_frame(65, 4'b0011, 16'h6C39, 16'h9A0B, "R11");
      check_frame(97, 4'b0011, 16'h0, 16'h0, "R9");

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #1600000;
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule